// File: doc/BRIEF.md
# Serial Management Link Command Transmitter

This block turns one management request into a serial command on a point-to-point link. The request comes in over a valid/ready handshake and carries a target id, an operation (read, write, data-poll or terminate), a 21-bit address, a transfer size code and up to four write bytes. The block packs these fields into a frame and appends a 4-bit CRC. It then produces the link clock and drives the frame out on an active-low data line, starting with a start bit and sending the most significant bit first.

After the last CRC bit the line is held at its idle level for a fixed number of bit periods, so the far end has time to turn the line around. The block then releases the line and pulses a done flag, which is the point where a separate receiver takes over. The level-translator direction output follows the drive state, so the pin buffer turns around in step with the data line.

Top module: `lnk_cmd_tx`

## Requirements
- R1: `req_ready_o` is high while idle. A request is taken at a clock edge where `req_valid_i` and `req_ready_o` are both high, and `req_ready_o` stays low from that edge until the done pulse.
- R2: After reset `link_clk_o`=1, `link_data_o`=1, `link_dir_o`=0, `req_ready_o`=1 and `done_o`=0.
- R3: Each bit period lasts two system clock cycles. `link_clk_o` is low in the first cycle and high in the second. `link_data_o` changes only as a low half begins, so it is stable across every rising edge of `link_clk_o`.
- R4: In the first bit period after acceptance, the line is driven low as the start bit.
- R5: The wire level is the inverse of each logical frame bit, and bits go out most significant first.
- R6: `req_op_i` is encoded as 0 for read, 1 for write, 2 for data-poll and 3 for terminate. A read or write frame is sent in this order: id (2 bits), command 3'b100, a direction bit (1 for read, 0 for write), 21 address bits, a size bit, and then, for writes only, the data bytes. Byte `req_wdata_i[7:0]` is sent first.
- R7: `req_size_i` is encoded as 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. For 1 byte the address is sent as given and the size bit is 0. For 2 bytes, address bit 0 is sent as 0 and the size bit is 1. For 4 bytes, address bits 1:0 are sent as 01 and the size bit is 1.
- R8: A data-poll frame is the id followed by 3'b010. A terminate frame is the id followed by 6'b111111. Neither frame uses the address, size or data inputs.
- R9: Every frame ends with a 4-bit CRC. The CRC uses polynomial x^4+x+1, starts from 0, is sent most significant bit first, and is computed over a logical 1 for the start bit followed by every frame bit.
- R10: After the CRC come 16 bit periods with the line high. `link_dir_o` is 1 from the start bit to the end of this echo delay.
- R11: `done_o` is a single-cycle pulse in the cycle right after the last echo period. In that cycle `link_dir_o` is 0 and `req_ready_o` is 1.
- R12: While a frame is in progress, `req_valid_i` and the request fields have no effect on the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Ready to take a request |
| req_id_i | input | 2 | Target id |
| req_op_i | input | 2 | Operation: 0 read, 1 write, 2 data-poll, 3 terminate |
| req_addr_i | input | 21 | Address |
| req_size_i | input | 2 | Size code: 0 one byte, 1 two bytes, 2 or 3 four bytes |
| req_wdata_i | input | 32 | Write data; bits 7:0 are sent first |
| link_clk_o | output | 1 | Link clock, idles high |
| link_data_o | output | 1 | Active-low serial data; valid while `link_dir_o` is 1 |
| link_dir_o | output | 1 | Level-translator direction: 1 while the block drives the line |
| done_o | output | 1 | One-cycle pulse at handoff to the receiver |

## Verification
The embedded properties assume a few things about the inputs. Each operation code used is one of the four defined values. Once a request is accepted, the request fields only matter at the accepting edge. The link is only watched between acceptance and the done pulse. The stimulus drives inputs half a cycle away from the active edge and waits for ready before raising valid. In one test it deliberately holds valid high with changing fields during a frame, then drops valid before the done pulse so that no second request slips in by accident. Operation, id, address, size and data are randomized alongside directed cases for every size code, all-ones addresses, and the poll and terminate frames.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_POLL  = 2'd2,
    OP_TERM  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_SHIFT,
    ST_CRC,
    ST_ECHO
  } st_e;

  localparam logic [2:0] CMD_ACCESS = 3'd4;
  localparam logic [2:0] CMD_POLL   = 3'd2;
  localparam logic [5:0] CMD_TERM   = 6'h3f;
endpackage

// File: rtl/lnk_frame_pack.sv
// Left-aligned frame (without CRC) and its length; DATA_W is 32 for the 4-byte size code.
module lnk_frame_pack import lnk_pkg::*; #(
  parameter int ID_W    = 2,
  parameter int ADDR_W  = 21,
  parameter int DATA_W  = 32,
  localparam int HDR_W   = ID_W + 3 + 1 + ADDR_W + 1,
  localparam int FRAME_W = HDR_W + DATA_W,
  localparam int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic [ID_W-1:0]    id_i,
  input  op_e                op_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [1:0]         size_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [LEN_W-1:0]   len_o
);
  localparam int BYTES = DATA_W / 8;

  logic [ADDR_W-1:0] addr_enc;
  logic              ds;
  int                nbytes;

  always_comb begin
    addr_enc = addr_i;
    ds       = 1'b0;
    nbytes   = 1;
    case (size_i)
      2'd0: ;
      2'd1: begin addr_enc[0] = 1'b0; ds = 1'b1; nbytes = 2; end
      default: begin addr_enc[1:0] = 2'b01; ds = 1'b1; nbytes = 4; end
    endcase
  end

  always_comb begin
    frame_o = '0;
    len_o   = '0;
    case (op_i)
      OP_READ, OP_WRITE: begin
        frame_o[FRAME_W-1 -: HDR_W] = {id_i, CMD_ACCESS, op_i == OP_READ, addr_enc, ds};
        len_o = LEN_W'(HDR_W);
        if (op_i == OP_WRITE) begin
          for (int b = 0; b < BYTES; b++)
            if (b < nbytes)
              frame_o[FRAME_W-1-HDR_W-8*b -: 8] = wdata_i[8*b +: 8];
          len_o = LEN_W'(HDR_W + 8 * nbytes);
        end
      end
      OP_POLL: begin
        frame_o[FRAME_W-1 -: ID_W+3] = {id_i, CMD_POLL};
        len_o = LEN_W'(ID_W + 3);
      end
      default: begin
        frame_o[FRAME_W-1 -: ID_W+6] = {id_i, CMD_TERM};
        len_o = LEN_W'(ID_W + 6);
      end
    endcase
  end
endmodule

// File: rtl/lnk_crc4.sv
module lnk_crc4 #(
  parameter logic [3:0] POLY = 4'b0011
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  input  logic shift_i,
  input  logic bit_i,
  output logic msb_o
);
  logic [3:0] crc_q;
  logic       fb;

  assign fb    = crc_q[3] ^ bit_i;
  assign msb_o = crc_q[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clr_i)   crc_q <= '0;
    else if (step_i)  crc_q <= {crc_q[2:0], 1'b0} ^ (fb ? POLY : 4'b0000);
    else if (shift_i) crc_q <= {crc_q[2:0], 1'b0};
  end
endmodule

// File: rtl/lnk_cmd_tx.sv
module lnk_cmd_tx import lnk_pkg::*; #(
  parameter int ID_W     = 2,
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 32,
  parameter int ECHO_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              link_clk_o,
  output logic              link_data_o,
  output logic              link_dir_o,
  output logic              done_o
);
  localparam int HDR_W   = ID_W + 3 + 1 + ADDR_W + 1;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam int CNT_MAX = (FRAME_W > ECHO_CYC) ? FRAME_W : ECHO_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  st_e                state_q;
  logic               ph_q;
  logic [FRAME_W-1:0] frame_q, pay_frame;
  logic [LEN_W-1:0]   pay_len;
  logic [CNT_W-1:0]   cnt_q;
  logic               done_q;
  logic               accept, bit_end, cur_bit, crc_msb;

  lnk_frame_pack #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pack (
    .id_i   (req_id_i),
    .op_i   (op_e'(req_op_i)),
    .addr_i (req_addr_i),
    .size_i (req_size_i),
    .wdata_i(req_wdata_i),
    .frame_o(pay_frame),
    .len_o  (pay_len)
  );

  assign accept  = req_valid_i && (state_q == ST_IDLE);
  assign bit_end = ph_q && (state_q != ST_IDLE);

  always_comb begin
    case (state_q)
      ST_START: cur_bit = 1'b1;
      ST_SHIFT: cur_bit = frame_q[FRAME_W-1];
      ST_CRC:   cur_bit = crc_msb;
      default:  cur_bit = 1'b0;
    endcase
  end

  lnk_crc4 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .step_i (bit_end && (state_q == ST_START || state_q == ST_SHIFT)),
    .shift_i(bit_end && state_q == ST_CRC),
    .bit_i  (cur_bit),
    .msb_o  (crc_msb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= 1'b0;
      frame_q <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= ST_START;
        ph_q    <= 1'b0;
        frame_q <= pay_frame;
        cnt_q   <= CNT_W'(pay_len - LEN_W'(1));
      end else if (state_q != ST_IDLE) begin
        ph_q <= ~ph_q;
        if (bit_end) begin
          case (state_q)
            ST_START: state_q <= ST_SHIFT;
            ST_SHIFT: begin
              frame_q <= frame_q << 1;
              if (cnt_q == '0) begin
                state_q <= ST_CRC;
                cnt_q   <= CNT_W'(3);
              end else cnt_q <= cnt_q - 1'b1;
            end
            ST_CRC: begin
              if (cnt_q == '0) begin
                state_q <= ST_ECHO;
                cnt_q   <= CNT_W'(ECHO_CYC - 1);
              end else cnt_q <= cnt_q - 1'b1;
            end
            default: begin
              if (cnt_q == '0) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end else cnt_q <= cnt_q - 1'b1;
            end
          endcase
        end
      end
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign link_clk_o  = (state_q == ST_IDLE) || ph_q;
  assign link_data_o = ~cur_bit;
  assign link_dir_o  = (state_q != ST_IDLE);
  assign done_o      = done_q;

  a_r1_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  a_r3_data_stable_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_clk_o) |-> $stable(link_data_o));

  a_r4_start_bit_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (!link_data_o && !link_clk_o && link_dir_o));

  a_r6_legal_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> (pay_len == LEN_W'(ID_W + 3) || pay_len == LEN_W'(ID_W + 6) ||
                pay_len == LEN_W'(HDR_W) || pay_len == LEN_W'(HDR_W + 8) ||
                pay_len == LEN_W'(HDR_W + 16) || pay_len == LEN_W'(HDR_W + 32)));

  a_r11_done_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (req_ready_o && !link_dir_o && $past(link_dir_o)));
endmodule

// File: tb/tb_lnk_cmd_tx.sv
`timescale 1ns/1ps
module tb_lnk_cmd_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_id = '0;
  logic [1:0]  req_op = '0;
  logic [20:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        link_clk, link_data, link_dir, done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic lb [0:127];
  int   ln;
  logic cap [0:255];

  always #4 clk = ~clk;

  lnk_cmd_tx dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_id_i(req_id), .req_op_i(req_op), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_wdata_i(req_wdata),
    .link_clk_o(link_clk), .link_data_o(link_data),
    .link_dir_o(link_dir), .done_o(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) begin
      lb[ln] = v[i];
      ln++;
    end
  endtask

  // logical frame including CRC, into lb[0:ln-1]
  task automatic build(input logic [1:0] op, input logic [1:0] id, input logic [20:0] addr,
                       input logic [1:0] sz, input logic [31:0] wd);
    logic [20:0] a;
    logic        ds;
    logic [3:0]  c;
    logic        fb;
    int          nb;
    ln = 0;
    push({30'd0, id}, 2);
    if (op == 2'd0 || op == 2'd1) begin
      push(32'd4, 3);
      push({31'd0, op == 2'd0}, 1);
      a = addr; ds = 1'b0; nb = 1;
      if (sz == 2'd1) begin a[0] = 1'b0; ds = 1'b1; nb = 2; end
      else if (sz >= 2'd2) begin a = (addr & ~21'd3) | 21'd1; ds = 1'b1; nb = 4; end
      push({11'd0, a}, 21);
      push({31'd0, ds}, 1);
      if (op == 2'd1)
        for (int b = 0; b < nb; b++) push({24'd0, wd[8*b +: 8]}, 8);
    end else if (op == 2'd2) begin
      push(32'd2, 3);
    end else begin
      push(32'h3f, 6);
    end
    c = 4'd0;
    fb = c[3] ^ 1'b1;
    c = {c[2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
    for (int i = 0; i < ln; i++) begin
      fb = c[3] ^ lb[i];
      c = {c[2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
    end
    push({28'd0, c}, 4);
  endtask

  task automatic send(input logic [1:0] op, input logic [1:0] id, input logic [20:0] addr,
                      input logic [1:0] sz, input logic [31:0] wd, input bit noisy, input string tag);
    int cyc, nb, bad_idx;
    logic pclk, pdat;
    bit busy_err, stab_err;
    logic exp_b;
    build(op, id, addr, sz, wd);
    @(negedge clk);
    check({"R1 ready idle ", tag}, req_ready, 1'b1);
    req_valid = 1'b1; req_op = op; req_id = id; req_addr = addr; req_size = sz; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    if (noisy) begin
      req_op = 2'($urandom); req_id = 2'($urandom); req_addr = 21'($urandom);
      req_size = 2'($urandom); req_wdata = $urandom;
    end else req_valid = 1'b0;
    check({"R1 ready low after accept ", tag}, req_ready, 1'b0);
    check({"R4 start bit low ", tag}, {link_dir, link_clk, link_data}, 3'b100);
    cyc = 1; nb = 0; busy_err = 0; stab_err = 0;
    pclk = link_clk; pdat = link_data;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (noisy && cyc == 20) begin
        req_valid = 1'b0;
        req_op = 2'($urandom); req_addr = 21'($urandom); req_wdata = $urandom;
      end
      if (!done && (!link_dir || req_ready)) busy_err = 1;
      if (pclk == 1'b0 && link_clk == 1'b1) begin
        if (link_data !== pdat) stab_err = 1;
        if (nb < 256) cap[nb] = link_data;
        nb++;
      end
      pclk = link_clk; pdat = link_data;
    end
    check({"R10 drive and busy held ", tag}, busy_err, 1'b0);
    check({"R3 stable across rise ", tag}, stab_err, 1'b0);
    check({"R3 done latency ", tag}, cyc, 2 * (1 + ln + 16) + 1);
    check({"R11 release at done ", tag}, {done, req_ready, link_dir}, 3'b110);
    check({"R10 period count ", tag}, nb, 1 + ln + 16);
    bad_idx = -1;
    for (int i = 0; i < 1 + ln + 16 && i < nb; i++) begin
      if (i == 0) exp_b = 1'b0;
      else if (i <= ln) exp_b = ~lb[i-1];
      else exp_b = 1'b1;
      if (cap[i] !== exp_b && bad_idx < 0) bad_idx = i;
    end
    check({"R5 R6 R7 R8 R9 R12 wire bits (first bad index) ", tag}, bad_idx, -1);
    @(negedge clk);
    check({"R11 done single pulse ", tag}, {done, req_ready}, 2'b01);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    #20;
    @(negedge clk);
    check("R2 reset outputs", {link_clk, link_data, link_dir, req_ready, done}, 5'b11010);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 idle after reset", {link_clk, link_data, link_dir, req_ready, done}, 5'b11010);
    // R6 R7 directed
    send(2'd0, 2'd0, 21'h000000, 2'd0, 32'h0,        0, "R6 read 1B");
    send(2'd0, 2'd3, 21'h1fffff, 2'd1, 32'h0,        0, "R7 read 2B all-ones");
    send(2'd0, 2'd1, 21'h1fffff, 2'd2, 32'h0,        0, "R7 read 4B all-ones");
    send(2'd0, 2'd2, 21'h0abcde, 2'd3, 32'h0,        0, "R7 read size code 3");
    send(2'd1, 2'd2, 21'h012345, 2'd0, 32'hffffffa5, 0, "R6 write 1B");
    send(2'd1, 2'd1, 21'h1fffff, 2'd1, 32'h00003cc3, 0, "R7 write 2B");
    send(2'd1, 2'd3, 21'h155555, 2'd2, 32'h12345678, 0, "R6 write 4B order");
    send(2'd2, 2'd1, 21'h1fffff, 2'd2, 32'hffffffff, 0, "R8 poll");
    send(2'd3, 2'd2, 21'h0,      2'd0, 32'h0,        0, "R8 terminate");
    send(2'd3, 2'd3, 21'h1fffff, 2'd3, 32'hffffffff, 0, "R9 terminate id3");
    send(2'd1, 2'd0, 21'h000003, 2'd2, 32'h80000001, 1, "R12 noisy inputs");
    for (int k = 0; k < 30; k++)
      send(2'($urandom), 2'($urandom), 21'($urandom), 2'($urandom), $urandom,
           ($urandom % 4) == 0, "R9 random");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule